// File: doc/BRIEF.md
# Buffered DAC Waveform Playback Engine

This block streams stored sample sequences to a set of DAC channels (four by default, 12 bits each). Every channel owns a private sample memory, a programmed playback length and a mode bit that picks between a single pass and endless repetition. A host fills the memories through a write port, programs length and mode, and then sends coded commands per channel: do nothing, start or stop.

All channels are paced by a single shared tick input, produced by an external timer. On each tick, every running channel places its next sample on its DAC data lane and pulses that lane's strobe one clock later. When a channel is idle, the host can also write a value straight to its DAC lane, bypassing the memory. A direct write to a running channel is refused and flagged.

Top module: `dac_wave_player`

## Requirements
- R1: After reset every channel is idle (`busy` low), all DAC lanes read zero, no strobe is high and the `len_err` and `dw_reject` flags are low.
- R2: `wr_en` stores `wr_data` at address `wr_addr` of the memory of channel `wr_ch`. `cfg_en` programs the length and mode of channel `cfg_ch`. A length above DEPTH is clamped to DEPTH.
- R3: In single-pass mode (`cfg_loop`=0), a running channel outputs sample k (k = 0,1,...) on its lane, with its strobe high, in the cycle after the k-th tick. After the sample at address len-1, `busy` drops in that same cycle, the last sample stays on the lane, and later ticks produce no strobe.
- R4: In repeat mode (`cfg_loop`=1), the address after len-1 is 0 and `busy` stays high until a stop command.
- R5: Command codes on `cmd_code` with `cmd_en`: 0 and 3 have no effect, 1 starts channel `cmd_ch` from address 0 (restarting it if it is already running), and 2 stops it. `busy` rises only after a start.
- R6: A stop drops `busy` in the next cycle and keeps the current lane value. The next start plays from address 0 again.
- R7: A start while the programmed length is zero does not change `busy` and sets that channel's `len_err`. The next start with a nonzero length clears `len_err`.
- R8: A direct write (`dw_en`, `dw_ch`, `dw_data`) to an idle channel appears on its lane with its strobe high in the next cycle.
- R9: A direct write to a running channel raises that channel's `dw_reject` for one cycle. The lane value does not change unless a tick occurs in the same cycle.
- R10: Channels run independently from the one shared tick. A strobe appears only after a tick on a running channel or after an accepted direct write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Shared pacing tick, one cycle wide |
| wr_en | input | 1 | Sample memory write enable |
| wr_ch | input | CW | Channel of the memory write |
| wr_addr | input | AW | Memory address |
| wr_data | input | DW | Sample value |
| cfg_en | input | 1 | Length and mode program enable |
| cfg_ch | input | CW | Channel being programmed |
| cfg_len | input | LW | Playback length in samples |
| cfg_loop | input | 1 | 1 = repeat, 0 = single pass |
| cmd_en | input | 1 | Command valid |
| cmd_ch | input | CW | Command channel |
| cmd_code | input | 2 | 0 none, 1 start, 2 stop, 3 none |
| dw_en | input | 1 | Direct write valid |
| dw_ch | input | CW | Direct write channel |
| dw_data | input | DW | Direct write value |
| dac_data | output | NCH*DW | DAC lanes, channel i at bits i*DW +: DW |
| dac_strobe | output | NCH | Per-lane update strobe |
| busy | output | NCH | Channel running |
| len_err | output | NCH | Zero-length start seen |
| dw_reject | output | NCH | Direct write refused (one-cycle pulse) |

## Verification
The hardest situations to reach are the interactions at the end of a buffer: the tick that consumes address len-1 and must both drop `busy` and hold the value, or must wrap to 0 in repeat mode. These are also the collisions between a running channel and a direct write or a stop. The bench reaches them with a sweep over every channel and every length from 1 to DEPTH on a small memory, issuing ticks one at a time and checking each sample. It then drives an extra tick past the end, plus dedicated sequences that stop mid-run, wrap several times, start with zero length, and write directly into a busy channel.

// File: rtl/dwp_pkg.sv
package dwp_pkg;
  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_START = 2'd1,
    CMD_STOP  = 2'd2,
    CMD_RSVD  = 2'd3
  } dwp_cmd_e;
endpackage

// File: rtl/dwp_sample_mem.sv
module dwp_sample_mem #(
  parameter int DW    = 12,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dwp_channel.sv
module dwp_channel #(
  parameter int DW    = 12,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cfg_en,
  input  logic [LW-1:0] cfg_len,
  input  logic          cfg_loop,
  input  logic          start,
  input  logic          stop,
  input  logic          dw_en,
  input  logic [DW-1:0] dw_data,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] raddr,
  output logic [DW-1:0] out,
  output logic          strobe,
  output logic          running,
  output logic          err,
  output logic          reject
);
  localparam logic [LW-1:0] MAXLEN = LW'(DEPTH);

  logic [LW-1:0] len_q, len_d;
  logic          loop_q, loop_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic [DW-1:0] out_q, out_d;
  logic          run_q, run_d, stb_q, stb_d, err_q, err_d, rej_q, rej_d;
  logic          at_end;

  assign at_end = ({1'b0, ptr_q} + (LW+1)'(1)) >= {1'b0, len_q};

  always_comb begin
    len_d  = len_q;
    loop_d = loop_q;
    if (cfg_en) begin
      len_d  = (cfg_len > MAXLEN) ? MAXLEN : cfg_len;
      loop_d = cfg_loop;
    end
  end

  always_comb begin
    run_d = run_q;
    ptr_d = ptr_q;
    out_d = out_q;
    stb_d = 1'b0;
    err_d = err_q;
    rej_d = 1'b0;
    if (start) begin
      if (len_q == '0) begin
        err_d = 1'b1;
      end else begin
        run_d = 1'b1;
        ptr_d = '0;
        err_d = 1'b0;
      end
    end else if (stop) begin
      run_d = 1'b0;
      ptr_d = '0;
    end else if (run_q && tick) begin
      out_d = rdata;
      stb_d = 1'b1;
      if (at_end) begin
        ptr_d = '0;
        if (!loop_q) run_d = 1'b0;
      end else begin
        ptr_d = ptr_q + AW'(1);
      end
    end
    if (dw_en) begin
      if (run_q) begin
        rej_d = 1'b1;
      end else begin
        out_d = dw_data;
        stb_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      loop_q <= 1'b0;
      ptr_q  <= '0;
      out_q  <= '0;
      run_q  <= 1'b0;
      stb_q  <= 1'b0;
      err_q  <= 1'b0;
      rej_q  <= 1'b0;
    end else begin
      len_q  <= len_d;
      loop_q <= loop_d;
      ptr_q  <= ptr_d;
      out_q  <= out_d;
      run_q  <= run_d;
      stb_q  <= stb_d;
      err_q  <= err_d;
      rej_q  <= rej_d;
    end
  end

  assign raddr   = ptr_q;
  assign out     = out_q;
  assign strobe  = stb_q;
  assign running = run_q;
  assign err     = err_q;
  assign reject  = rej_q;

  a_r2_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    len_q <= MAXLEN);
  a_r3_single_pass_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick && !loop_q && at_end && !start && !stop) |=> !run_q);
  a_r4_loop_keeps_running: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick && loop_q && !stop) |=> run_q);
  a_r5_rise_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> $past(start));
  a_r6_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start && run_q) |=> (!run_q && $stable(out_q) && ptr_q == '0));
  a_r7_zero_len_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start && len_q == '0) |=> (err_q && $stable(run_q)));
  a_r9_reject_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (dw_en && run_q) |=> rej_q);
  a_r9_reject_keeps_out: assert property (@(posedge clk) disable iff (!rst_n)
    (dw_en && run_q && !tick) |=> $stable(out_q));
endmodule

// File: rtl/dac_wave_player.sv
module dac_wave_player #(
  parameter int NCH   = 4,
  parameter int DW    = 12,
  parameter int DEPTH = 1024,
  localparam int CW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [CW-1:0]     wr_ch,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              cfg_en,
  input  logic [CW-1:0]     cfg_ch,
  input  logic [LW-1:0]     cfg_len,
  input  logic              cfg_loop,
  input  logic              cmd_en,
  input  logic [CW-1:0]     cmd_ch,
  input  logic [1:0]        cmd_code,
  input  logic              dw_en,
  input  logic [CW-1:0]     dw_ch,
  input  logic [DW-1:0]     dw_data,
  output logic [NCH*DW-1:0] dac_data,
  output logic [NCH-1:0]    dac_strobe,
  output logic [NCH-1:0]    busy,
  output logic [NCH-1:0]    len_err,
  output logic [NCH-1:0]    dw_reject
);
  import dwp_pkg::*;

  dwp_cmd_e cmd;
  assign cmd = dwp_cmd_e'(cmd_code);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic          sel_wr, sel_cfg, sel_cmd, sel_dw;
    logic [AW-1:0] raddr;
    logic [DW-1:0] rdata;

    assign sel_wr  = wr_en  && (wr_ch  == CW'(i));
    assign sel_cfg = cfg_en && (cfg_ch == CW'(i));
    assign sel_cmd = cmd_en && (cmd_ch == CW'(i));
    assign sel_dw  = dw_en  && (dw_ch  == CW'(i));

    dwp_sample_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
      .clk   (clk),
      .we    (sel_wr),
      .waddr (wr_addr),
      .wdata (wr_data),
      .raddr (raddr),
      .rdata (rdata)
    );

    dwp_channel #(.DW(DW), .DEPTH(DEPTH)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .cfg_en   (sel_cfg),
      .cfg_len  (cfg_len),
      .cfg_loop (cfg_loop),
      .start    (sel_cmd && cmd == CMD_START),
      .stop     (sel_cmd && cmd == CMD_STOP),
      .dw_en    (sel_dw),
      .dw_data  (dw_data),
      .rdata    (rdata),
      .raddr    (raddr),
      .out      (dac_data[i*DW +: DW]),
      .strobe   (dac_strobe[i]),
      .running  (busy[i]),
      .err      (len_err[i]),
      .reject   (dw_reject[i])
    );
  end

  a_r10_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_strobe != '0) |-> $past(tick || dw_en));
endmodule

// File: tb/dac_wave_player_tb.sv
module dac_wave_player_tb;
  localparam int NCH = 4, DW = 12, DEPTH = 8;
  localparam int CW = 2, AW = 3, LW = 4;

  logic clk = 0, rst_n = 0;
  logic tick = 0, wr_en = 0, cfg_en = 0, cfg_loop = 0, cmd_en = 0, dw_en = 0;
  logic [CW-1:0] wr_ch = 0, cfg_ch = 0, cmd_ch = 0, dw_ch = 0;
  logic [AW-1:0] wr_addr = 0;
  logic [DW-1:0] wr_data = 0, dw_data = 0;
  logic [LW-1:0] cfg_len = 0;
  logic [1:0]    cmd_code = 0;
  logic [NCH*DW-1:0] dac_data;
  logic [NCH-1:0] dac_strobe, busy, len_err, dw_reject;

  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  dac_wave_player #(.NCH(NCH), .DW(DW), .DEPTH(DEPTH)) u_dut (.*);

  function automatic int smp(int ch, int k);
    return (ch * 256 + k * 17 + 3) & 12'hFFF;
  endfunction

  function automatic int lane(int ch);
    return int'(dac_data[ch*DW +: DW]);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic cfg(input int ch, input int len, input bit lp);
    cfg_en = 1; cfg_ch = CW'(ch); cfg_len = LW'(len); cfg_loop = lp;
    cyc(); cfg_en = 0;
  endtask

  task automatic cmd(input int ch, input int code);
    cmd_en = 1; cmd_ch = CW'(ch); cmd_code = 2'(code);
    cyc(); cmd_en = 0;
  endtask

  task automatic do_tick();
    tick = 1; cyc(); tick = 0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    cyc(); cyc();
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 data", int'(dac_data != 0), 0);
    chk("R1 strobe", int'(dac_strobe), 0);
    chk("R1 flags", int'({len_err, dw_reject}), 0);
    rst_n = 1; cyc();

    // R2 load every memory
    for (int c = 0; c < NCH; c++)
      for (int a = 0; a < DEPTH; a++) begin
        wr_en = 1; wr_ch = CW'(c); wr_addr = AW'(a); wr_data = DW'(smp(c, a));
        cyc();
      end
    wr_en = 0;

    // R3 single-pass sweep over all channels and lengths
    for (int c = 0; c < NCH; c++)
      for (int L = 1; L <= DEPTH; L++) begin
        cfg(c, L, 0);
        cmd(c, 1);
        chk("R5 busy after start", int'(busy[c]), 1);
        for (int k = 0; k < L; k++) begin
          do_tick();
          chk("R3 sample", lane(c), smp(c, k));
          chk("R3 strobe", int'(dac_strobe), 1 << c);
          chk("R3 busy", int'(busy[c]), (k == L - 1) ? 0 : 1);
        end
        do_tick();
        chk("R3 no strobe past end", int'(dac_strobe), 0);
        chk("R3 last held", lane(c), smp(c, L - 1));
      end

    // R4 repeat mode, R6 stop
    cfg(1, 3, 1);
    cmd(1, 1);
    for (int k = 0; k < 8; k++) begin
      do_tick();
      chk("R4 wrap sample", lane(1), smp(1, k % 3));
      chk("R4 busy", int'(busy[1]), 1);
    end
    cmd(1, 2);
    chk("R6 busy after stop", int'(busy[1]), 0);
    chk("R6 value held", lane(1), smp(1, 7 % 3));
    do_tick();
    chk("R6 no strobe after stop", int'(dac_strobe), 0);
    chk("R6 value held tick", lane(1), smp(1, 1));
    cmd(1, 1);
    do_tick();
    chk("R6 restart from 0", lane(1), smp(1, 0));
    do_tick();
    // R5 restart while running
    cmd(1, 1);
    do_tick();
    chk("R5 restart running", lane(1), smp(1, 0));
    // R5 codes 0 and 3 ignored
    cmd(1, 0); cmd(1, 3);
    chk("R5 code 0/3 keep running", int'(busy[1]), 1);
    cmd(1, 2);
    cmd(2, 0); cmd(2, 3);
    chk("R5 code 0/3 no start", int'(busy), 0);

    // R10 independent channels
    cfg(0, 2, 1); cfg(3, 4, 0);
    cmd(0, 1); cmd(3, 1);
    for (int k = 0; k < 6; k++) begin
      do_tick();
      chk("R10 ch0", lane(0), smp(0, k % 2));
      chk("R10 ch3", lane(3), smp(3, (k < 4) ? k : 3));
      chk("R10 strobes", int'(dac_strobe), (k < 4) ? 9 : 1);
    end
    cmd(0, 2);

    // R7 zero length
    cfg(2, 0, 0);
    cmd(2, 1);
    chk("R7 err set", int'(len_err[2]), 1);
    chk("R7 not started", int'(busy[2]), 0);
    cfg(2, 3, 0);
    cmd(2, 1);
    chk("R7 err cleared", int'(len_err[2]), 0);
    chk("R7 valid start", int'(busy[2]), 1);
    cmd(2, 2);

    // R2 clamp of length
    cfg(0, 15, 0);
    cmd(0, 1);
    for (int k = 0; k < DEPTH; k++) begin
      do_tick();
      chk("R2 clamp busy", int'(busy[0]), (k == DEPTH - 1) ? 0 : 1);
    end
    chk("R2 clamp last", lane(0), smp(0, DEPTH - 1));

    // R8 direct write idle
    dw_en = 1; dw_ch = 2; dw_data = 12'hABC; cyc(); dw_en = 0;
    chk("R8 direct value", lane(2), 12'hABC);
    chk("R8 direct strobe", int'(dac_strobe), 4);
    cyc();
    chk("R10 strobe single cycle", int'(dac_strobe), 0);

    // R9 direct write rejected while busy
    cfg(2, 2, 1);
    cmd(2, 1);
    do_tick();
    dw_en = 1; dw_ch = 2; dw_data = 12'h123; cyc(); dw_en = 0;
    chk("R9 reject", int'(dw_reject), 4);
    chk("R9 value unchanged", lane(2), smp(2, 0));
    chk("R9 no strobe", int'(dac_strobe), 0);
    cyc();
    chk("R9 reject pulse", int'(dw_reject), 0);
    cmd(2, 2);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule